// File: doc/BRIEF.md
# 10-bit Address I2C Target

This block is an I2C target that sits on a shared two-wire bus and responds only to one 10-bit address. It samples SCL and SDA with the system clock and watches the bus for START, repeated START and STOP conditions. It decodes the two-byte 10-bit address phase and pulls SDA low through an open-drain enable to acknowledge the bytes it accepts.

In a write, each data byte after the address phase is acknowledged and presented for one clock on a byte-valid strobe. A read starts as a write-addressed phase. The controller then issues a repeated START and sends the prefix byte again with the read bit set. The target then sends a fixed reply: a constant byte, followed by a transaction counter with its most significant byte first. The counter advances once for every completed transaction that addressed this target. The value sent is captured when the read prefix is accepted, so it cannot change partway through a reply.

Top module: `i2c10_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe` and `rx_valid` are 0.
- R2: A first byte of 11110, then address bits 9:8, then R/W=0 is acknowledged. The following byte is acknowledged only when it equals address bits 7:0, so the whole 10-bit address must equal `OWN_ADDR` (default 0x2CF, giving first byte 0xF4).
- R3: A first byte with the wrong prefix or high bits is not acknowledged, and neither is a second byte with the wrong low bits. After such a byte the target leaves SDA released and raises no `rx_valid` until the next START.
- R4: After a matched write address, each data byte is received MSB first and acknowledged. It appears on `rx_data` with a one-cycle `rx_valid` pulse, and bytes appear in bus order.
- R5: After a matched write address, a repeated START followed by the read prefix byte (0xF5 for the default address) is acknowledged. The target then sends `REPLY_CONST` (default 0x5A), then the counter high byte, then the counter low byte, each MSB first.
- R6: A read prefix byte is not acknowledged unless the address phase since the last STOP fully matched. In that case the target stays silent.
- R7: The counter starts at 0 and increments by one at the STOP of each transaction whose address fully matched. It wraps modulo 2^`CNT_W`.
- R8: A controller NACK after a transmitted byte ends the reply, and SDA stays released until the next START.
- R9: The counter value sent is captured when the read prefix is accepted and stays stable during the reply.
- R10: `sda_oe` changes only while the synchronized SCL is low, or on a START or STOP condition.
- R11: If the controller acknowledges the last reply byte and keeps reading, the target leaves SDA released, so the extra bytes read as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High to pull SDA low (open-drain) |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte, valid with `rx_valid` |

## Verification
The assertions assume a single controller that holds each SCL phase for many system clocks, well beyond the three-cycle synchronizer and edge-detect delay. They also assume the controller changes SDA while SCL is high only to form START and STOP. The stimulus drives every SCL quarter phase for ten clocks and changes its own SDA only in the low phase, except when it builds START, repeated START and STOP. Under these rules the target's own SDA changes always fall in an SCL low phase.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HDR  = 3'd1,
      ST_LOW  = 3'd2,
      ST_RX   = 3'd3,
      ST_TX   = 3'd4
   } i2c10_state_e;

   localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '1;
            else        stg[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '1;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/i2c10_bus_cond.sv
module i2c10_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_d;
   logic sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c10_reply.sv
module i2c10_reply #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic             freeze,
   output logic [CNT_W-1:0] snap
);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         snap_q  <= '0;
      end else begin
         if (bump)   count_q <= count_q + 1'b1;
         if (freeze) snap_q  <= count_q;
      end
   end

   assign snap = snap_q;

endmodule

// File: rtl/i2c10_target.sv
module i2c10_target
   import i2c10_pkg::*;
#(
   parameter logic [9:0] OWN_ADDR    = 10'h2CF,
   parameter logic [7:0] REPLY_CONST = 8'h5A,
   parameter int         CNT_W       = 16,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       rx_valid,
   output logic [7:0] rx_data
);

   localparam int CNT_BYTES = CNT_W / 8;
   localparam int TX_BYTES  = CNT_BYTES + 1;
   localparam int IDX_W     = $clog2(TX_BYTES + 1);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TX_BYTES);

   if (CNT_W % 8 != 0 || CNT_W < 8 || CNT_W > 32) begin : g_bad_cnt
      $error("i2c10_target: CNT_W must be a multiple of 8 in 8..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c10_target: SYNC_STAGES must be at least 2");
   end

   // ---------------- input conditioning ----------------
   logic [1:0] bus_s;
   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;

   i2c10_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_i, sda_i}),
      .dout (bus_s)
   );
   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2c10_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   // ---------------- state ----------------
   i2c10_state_e     state;
   logic [3:0]       bit_cnt;
   logic [6:0]       sh_q;
   logic             matched;
   logic             ack_pend;
   logic             ack_drive;
   logic             tx_drive;
   logic [7:0]       tx_sh;
   logic             tx_first;
   logic [IDX_W-1:0] tx_idx;
   logic             rx_valid_q;
   logic [7:0]       rx_data_q;

   // ---------------- reply source ----------------
   logic             cnt_bump;
   logic             load_snap;
   logic [CNT_W-1:0] snap;

   i2c10_reply #(.CNT_W(CNT_W)) u_reply (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (cnt_bump),
      .freeze(load_snap),
      .snap  (snap)
   );

   logic [7:0] reply_tbl [TX_BYTES+1];
   for (genvar k = 0; k <= TX_BYTES; k++) begin : g_tbl
      if (k == 0) begin : g_const
         assign reply_tbl[k] = REPLY_CONST;
      end else if (k == TX_BYTES) begin : g_pad
         assign reply_tbl[k] = 8'hFF;
      end else begin : g_cnt
         assign reply_tbl[k] = snap[CNT_W-8*k +: 8];
      end
   end

   logic [IDX_W-1:0] nxt_idx;
   logic [7:0]       reply_byte;
   always_comb begin
      if (tx_first)               nxt_idx = '0;
      else if (tx_idx == IDX_END) nxt_idx = tx_idx;
      else                        nxt_idx = tx_idx + 1'b1;
   end
   assign reply_byte = reply_tbl[nxt_idx];

   // ---------------- byte decode ----------------
   logic [7:0] byte_in;
   logic       byte_done;
   logic       hdr_ok;
   logic       hdr_write;
   logic       hdr_read;
   logic       lo_ok;

   assign byte_in   = {sh_q, sda_s};
   assign byte_done = scl_rise && (bit_cnt == 4'd7) && !start_det && !stop_det
                      && (state != ST_IDLE);
   assign hdr_ok    = (byte_in[7:3] == TEN_BIT_PREFIX) && (byte_in[2:1] == OWN_ADDR[9:8]);
   assign hdr_write = hdr_ok && !byte_in[0];
   assign hdr_read  = hdr_ok && byte_in[0];
   assign lo_ok     = (byte_in == OWN_ADDR[7:0]);

   assign load_snap = byte_done && (state == ST_HDR) && hdr_read && matched;
   assign cnt_bump  = stop_det && matched;

   // ---------------- main sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         sh_q       <= '0;
         matched    <= 1'b0;
         ack_pend   <= 1'b0;
         ack_drive  <= 1'b0;
         tx_drive   <= 1'b0;
         tx_sh      <= 8'hFF;
         tx_first   <= 1'b0;
         tx_idx     <= '0;
         rx_valid_q <= 1'b0;
         rx_data_q  <= '0;
      end else begin
         rx_valid_q <= 1'b0;
         if (start_det) begin
            state     <= ST_HDR;
            bit_cnt   <= '0;
            ack_pend  <= 1'b0;
            ack_drive <= 1'b0;
            tx_drive  <= 1'b0;
         end else if (stop_det) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            matched   <= 1'b0;
            ack_pend  <= 1'b0;
            ack_drive <= 1'b0;
            tx_drive  <= 1'b0;
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (bit_cnt < 4'd8) begin
                  sh_q    <= byte_in[6:0];
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (bit_cnt == 4'd9 && state == ST_TX && sda_s) begin
                  // controller declined further data
                  state <= ST_IDLE;
               end
               if (byte_done) begin
                  unique case (state)
                     ST_HDR: begin
                        if (hdr_write) begin
                           ack_pend <= 1'b1;
                           matched  <= 1'b0;
                           state    <= ST_LOW;
                        end else if (hdr_read && matched) begin
                           ack_pend <= 1'b1;
                           tx_first <= 1'b1;
                           tx_idx   <= '0;
                           state    <= ST_TX;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     ST_LOW: begin
                        if (lo_ok) begin
                           ack_pend <= 1'b1;
                           matched  <= 1'b1;
                           state    <= ST_RX;
                        end else begin
                           matched <= 1'b0;
                           state   <= ST_IDLE;
                        end
                     end
                     ST_RX: begin
                        ack_pend   <= 1'b1;
                        rx_valid_q <= 1'b1;
                        rx_data_q  <= byte_in;
                     end
                     default: ;
                  endcase
               end
            end else if (scl_fall) begin
               if (bit_cnt == 4'd8) begin
                  ack_drive <= ack_pend;
                  tx_drive  <= 1'b0;
                  bit_cnt   <= 4'd9;
               end else if (bit_cnt == 4'd9) begin
                  ack_drive <= 1'b0;
                  ack_pend  <= 1'b0;
                  bit_cnt   <= '0;
                  if (state == ST_TX) begin
                     tx_first <= 1'b0;
                     tx_idx   <= nxt_idx;
                     tx_sh    <= reply_byte;
                     tx_drive <= 1'b1;
                  end
               end else if (bit_cnt != 4'd0 && state == ST_TX) begin
                  tx_sh <= {tx_sh[6:0], 1'b1};
               end
            end
         end
      end
   end

   assign sda_oe   = ack_drive | (tx_drive & ~tx_sh[7]);
   assign rx_valid = rx_valid_q;
   assign rx_data  = rx_data_q;

endmodule

// File: rtl/i2c10_target_chk.sv
module i2c10_target_chk
   import i2c10_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start_det,
   input logic             stop_det,
   input logic             sda_oe,
   input logic             rx_valid,
   input logic             matched,
   input i2c10_state_e     state,
   input logic             load_snap,
   input logic [CNT_W-1:0] snap
);

   // R10
   sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sda_oe) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

   // R4
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4
   rx_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> matched);

   // R9
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && $past(state) == ST_TX) |-> $stable(snap));

   // R9
   snap_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap) |-> $past(load_snap));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

endmodule

bind i2c10_target i2c10_target_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .start_det(start_det),
   .stop_det (stop_det),
   .sda_oe   (sda_oe),
   .rx_valid (rx_valid),
   .matched  (matched),
   .state    (state),
   .load_snap(load_snap),
   .snap     (snap)
);

// File: tb/tb_i2c10_target.sv
`timescale 1ns/1ps
module tb_i2c10_target;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_line;
   logic       sda_oe;
   logic       rx_valid;
   logic [7:0] rx_data;

   always #10 clk = ~clk;

   always_comb sda_line = !(m_low || sda_oe);

   i2c10_target dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl),
      .sda_i   (sda_line),
      .sda_oe  (sda_oe),
      .rx_valid(rx_valid),
      .rx_data (rx_data)
   );

   int         n_cmp = 0;
   int         n_bad = 0;
   int         exp_cnt = 0;
   bit         quiet = 1'b0;
   bit         done = 1'b0;
   logic [7:0] rx_q [$];
   int         scl_hi = 0;
   logic       prev_oe = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock reference comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (rx_q.size() == 0) chk("R4 unexpected byte", {24'd0, rx_data}, 32'hFFFF_FFFF);
            else                  chk("R4 rx byte", {24'd0, rx_data}, {24'd0, rx_q.pop_front()});
         end
         if (quiet) chk("R3 silent", {31'd0, sda_oe}, 32'd0);
         if (scl_hi >= 4) chk("R10 sda steady in high phase", {31'd0, sda_oe}, {31'd0, prev_oe});
      end
      scl_hi  = scl ? scl_hi + 1 : 0;
      prev_oe = sda_oe;
   end

   task automatic tq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_bit(input logic b);
      m_low = !b; tq(Q); scl = 1'b1; tq(2*Q); scl = 1'b0; tq(Q);
   endtask

   task automatic rd_bit(output logic b);
      m_low = 1'b0; tq(Q); scl = 1'b1; tq(Q); b = sda_line; tq(Q); scl = 1'b0; tq(Q);
   endtask

   task automatic bus_start();
      m_low = 1'b1; tq(2*Q); scl = 1'b0; tq(Q);
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; tq(Q); scl = 1'b1; tq(2*Q); m_low = 1'b1; tq(2*Q); scl = 1'b0; tq(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tq(Q); scl = 1'b1; tq(2*Q); m_low = 1'b0; tq(2*Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) wr_bit(b[i]);
      rd_bit(a);
      ack = !a;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         rd_bit(x);
         b[i] = x;
      end
      wr_bit(!give_ack);
   endtask

   // full write-addressed phase for 0x2CF (bytes 0xF4, 0xCF)
   task automatic addr_phase(input string req);
      logic a;
      wr_byte(8'hF4, a); chk({req, " hdr ack"}, {31'd0, a}, 32'd1);
      wr_byte(8'hCF, a); chk({req, " low ack"}, {31'd0, a}, 32'd1);
   endtask

   task automatic read_reply(input int nbytes, input logic nack_first);
      logic       a;
      logic [7:0] b;
      bus_start();
      addr_phase("R5");
      bus_rstart();
      wr_byte(8'hF5, a); chk("R5 read prefix ack", {31'd0, a}, 32'd1);
      if (nack_first) begin
         rd_byte(1'b0, b); chk("R5 const byte", {24'd0, b}, 32'h5A);
         rd_byte(1'b0, b); chk("R8 released after nack", {24'd0, b}, 32'hFF);
      end else begin
         rd_byte(1'b1, b); chk("R5 const byte", {24'd0, b}, 32'h5A);
         rd_byte(1'b1, b); chk("R7 counter high", {24'd0, b}, {16'd0, 8'(exp_cnt >> 8)});
         rd_byte(nbytes > 3, b); chk("R9 counter low", {24'd0, b}, {24'd0, 8'(exp_cnt)});
         if (nbytes > 3) begin
            rd_byte(1'b0, b); chk("R11 pad byte", {24'd0, b}, 32'hFF);
         end
      end
      bus_stop();
      exp_cnt++;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic a;
      tq(5);
      chk("R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
      chk("R1 rx_valid in reset", {31'd0, rx_valid}, 32'd0);
      rst_n = 1'b1;
      tq(4);
      chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);

      // R2 R4: matched write of 0xA5 then 0x5A
      bus_start();
      addr_phase("R2");
      rx_q.push_back(8'hA5);
      wr_byte(8'hA5, a); chk("R4 data ack 1", {31'd0, a}, 32'd1);
      rx_q.push_back(8'h5A);
      wr_byte(8'h5A, a); chk("R4 data ack 2", {31'd0, a}, 32'd1);
      bus_stop();
      exp_cnt++;

      // R5 R7: read the reply, counter = 1
      read_reply(3, 1'b0);

      // R3: wrong low address byte
      bus_start();
      wr_byte(8'hF4, a); chk("R2 hdr ack", {31'd0, a}, 32'd1);
      wr_byte(8'hCE, a); chk("R3 low nack", {31'd0, a}, 32'd0);
      quiet = 1'b1;
      wr_byte(8'h11, a); chk("R3 data ignored", {31'd0, a}, 32'd0);
      quiet = 1'b0;
      bus_stop();

      // R3: wrong high bits
      bus_start();
      wr_byte(8'hF6, a); chk("R3 hdr nack", {31'd0, a}, 32'd0);
      quiet = 1'b1;
      wr_byte(8'hCF, a); chk("R3 low ignored", {31'd0, a}, 32'd0);
      quiet = 1'b0;
      bus_stop();

      // R6: read prefix with no prior address phase
      bus_start();
      wr_byte(8'hF5, a); chk("R6 read prefix nack", {31'd0, a}, 32'd0);
      quiet = 1'b1;
      wr_byte(8'h00, a); chk("R6 stays idle", {31'd0, a}, 32'd0);
      quiet = 1'b0;
      bus_stop();

      // R8: controller NACKs the first reply byte
      read_reply(1, 1'b1);

      // R11: read past the reply, counter = 3
      read_reply(4, 1'b0);

      // R4: further write pattern
      bus_start();
      addr_phase("R2");
      rx_q.push_back(8'h00);
      wr_byte(8'h00, a); chk("R4 data ack 00", {31'd0, a}, 32'd1);
      rx_q.push_back(8'hFF);
      wr_byte(8'hFF, a); chk("R4 data ack FF", {31'd0, a}, 32'd1);
      rx_q.push_back(8'h3C);
      wr_byte(8'h3C, a); chk("R4 data ack 3C", {31'd0, a}, 32'd1);
      bus_stop();
      exp_cnt++;

      // R7: counter now 5
      read_reply(3, 1'b0);

      tq(10);
      chk("R4 all bytes delivered", rx_q.size(), 32'd0);
      chk("R8 sda released at end", {31'd0, sda_oe}, 32'd0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule